// File: doc/BRIEF.md
# Two-Thread Resource Throttle Controller

This block sits beside the dispatch stage of a two-thread core and watches how much of the shared machinery each thread is holding. It looks at two pressure indicators per thread: the number of outstanding second-level cache load misses, and the number of occupied entries in the group-completion table. When one thread reaches a programmable limit on either indicator while the other thread stays below its limits, the controller throttles only that thread. The goal is to keep the other thread flowing.

Throttling escalates in three steps as long as the pressure lasts. The first step is a priority-reduction request. After a programmable number of cycles, decode is also blocked. After a second, longer programmable count, a one-cycle flush pulse clears the thread's not-yet-dispatched instructions, and a level hold keeps it stalled. A thread is released only when both of its counts are back under their limits and the congestion-clear input for that thread is high. If both threads are over their limits at the same time, neither one is throttled, because throttling both could leave them blocking each other.

Top module: `throttle_balancer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, all throttle outputs of both threads are 0.
- R2: Thread t is over pressure when `miss_cnt_i[t] >= miss_limit_i`. If no thread is throttled and only thread t is over pressure, `prio_down_o[t]` is 1 after the next rising edge. A miss count one below the limit has no effect.
- R3: Thread t is also over pressure when `grp_cnt_i[t] >= grp_limit_i`. This starts throttling in the same way as R2.
- R4: Let the edge that set `prio_down_o[t]` be edge 0. Count edges at which thread t is still over pressure. At the edge where this count reaches `inhibit_after_i`, `decode_block_o[t]` goes to 1. `prio_down_o[t]` stays 1 whenever `decode_block_o[t]` is 1.
- R5: At the edge where the same count reaches `flush_after_i`, `flush_o[t]` goes to 1 for exactly one cycle. `hold_o[t]` goes to 1 and stays at 1, and `decode_block_o[t]` stays at 1.
- R6: At any rising edge where thread t is throttled, both of its counts are below their limits and `clr_i[t]` is 1, all four outputs of thread t go to 0.
- R7: Throttling one thread leaves every output of the other thread at 0.
- R8: A thread begins throttling only if the other thread is not over pressure and is not throttled. If both threads become over pressure together, neither is throttled. At most one `prio_down_o` bit is 1 at any time.
- R9: While a throttled thread is below its limits but `clr_i[t]` is 0, its throttle level holds and the escalation count pauses. If the thread goes over pressure again, escalation resumes from where it paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_cnt_i | input | 2*MISS_W | Outstanding L2 load misses per thread; thread t in slice t |
| grp_cnt_i | input | 2*GRP_W | Occupied completion-table entries per thread |
| miss_limit_i | input | MISS_W | Miss-count limit |
| grp_limit_i | input | GRP_W | Completion-entry limit |
| inhibit_after_i | input | DWELL_W | Over-pressure edges before decode is blocked |
| flush_after_i | input | DWELL_W | Over-pressure edges before the flush and hold |
| clr_i | input | 2 | Per-thread congestion-cleared indication |
| prio_down_o | output | 2 | Per-thread priority-reduction request |
| decode_block_o | output | 2 | Per-thread decode inhibit |
| flush_o | output | 2 | Per-thread one-cycle flush of undispatched instructions |
| hold_o | output | 2 | Per-thread decode hold that follows a flush |

## Verification
The hardest case to reach is a thread that has escalated part way, then drops below its limits while the clear input stays low, and then goes over pressure again. Only this sequence shows that the escalation count pauses instead of resetting or running on. The stimulus first drives thread 0 into decode-block. It then removes the pressure with the clear input held low for several cycles, and then raises the miss count again. The flush is expected exactly when the total number of over-pressure edges reaches the flush limit. A second sequence starts one thread and then pushes the other thread over its limits. This checks that the admission rule keeps the second thread unthrottled.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int NUM_THR = 2;

  typedef enum logic [1:0] {
    LVL_IDLE  = 2'd0,
    LVL_PRIO  = 2'd1,
    LVL_INHIB = 2'd2,
    LVL_HOLD  = 2'd3
  } thr_lvl_e;
endpackage

// File: rtl/thr_load_mon.sv
// Compares one pressure count against its limit.
module thr_load_mon #(
  parameter int CW = 5
) (
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] limit_i,
  output logic          over_o
);
  assign over_o = (count_i >= limit_i);
endmodule

// File: rtl/thr_admit.sv
// Admission rule: a thread may start throttling only when the other
// thread is neither over pressure nor already throttled.
module thr_admit #(
  parameter int NT = 2
) (
  input  logic [NT-1:0] over_i,
  input  logic [NT-1:0] idle_i,
  output logic [NT-1:0] start_o
);
  for (genvar t = 0; t < NT; t++) begin : g_adm
    localparam int OTH = NT - 1 - t;
    assign start_o[t] = over_i[t] && !over_i[OTH] && idle_i[OTH];
  end
endmodule

// File: rtl/thr_escalator.sv
// Per-thread escalation state machine with a saturating dwell counter.
module thr_escalator
  import thr_pkg::*;
#(
  parameter int DWELL_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               over_i,
  input  logic               clr_i,
  input  logic [DWELL_W-1:0] inh_lim_i,
  input  logic [DWELL_W-1:0] fl_lim_i,
  output logic               prio_o,
  output logic               blk_o,
  output logic               flush_o,
  output logic               hold_o,
  output logic               idle_o
);
  localparam logic [DWELL_W-1:0] CNT_MAX = {DWELL_W{1'b1}};

  thr_lvl_e           lvl_q, lvl_n;
  logic [DWELL_W-1:0] cnt_q, cnt_n;
  logic               fl_n;

  always_comb begin
    lvl_n = lvl_q;
    cnt_n = cnt_q;
    fl_n  = 1'b0;
    if (lvl_q == LVL_IDLE) begin
      if (start_i) begin
        lvl_n = LVL_PRIO;
        cnt_n = '0;
      end
    end else if (!over_i && clr_i) begin
      lvl_n = LVL_IDLE;
      cnt_n = '0;
    end else if (over_i) begin
      cnt_n = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      if (lvl_q != LVL_HOLD && cnt_n >= fl_lim_i) begin
        lvl_n = LVL_HOLD;
        fl_n  = 1'b1;
      end else if (lvl_q == LVL_PRIO && cnt_n >= inh_lim_i) begin
        lvl_n = LVL_INHIB;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= LVL_IDLE;
      cnt_q   <= '0;
      prio_o  <= 1'b0;
      blk_o   <= 1'b0;
      flush_o <= 1'b0;
      hold_o  <= 1'b0;
    end else begin
      lvl_q   <= lvl_n;
      cnt_q   <= cnt_n;
      prio_o  <= (lvl_n != LVL_IDLE);
      blk_o   <= (lvl_n == LVL_INHIB) || (lvl_n == LVL_HOLD);
      flush_o <= fl_n;
      hold_o  <= (lvl_n == LVL_HOLD);
    end
  end

  assign idle_o = !prio_o;
endmodule

// File: rtl/throttle_balancer.sv
module throttle_balancer
  import thr_pkg::*;
#(
  parameter int MISS_W  = 5,
  parameter int GRP_W   = 6,
  parameter int DWELL_W = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_THR-1:0][MISS_W-1:0]  miss_cnt_i,
  input  logic [NUM_THR-1:0][GRP_W-1:0]   grp_cnt_i,
  input  logic [MISS_W-1:0]               miss_limit_i,
  input  logic [GRP_W-1:0]                grp_limit_i,
  input  logic [DWELL_W-1:0]              inhibit_after_i,
  input  logic [DWELL_W-1:0]              flush_after_i,
  input  logic [NUM_THR-1:0]              clr_i,
  output logic [NUM_THR-1:0]              prio_down_o,
  output logic [NUM_THR-1:0]              decode_block_o,
  output logic [NUM_THR-1:0]              flush_o,
  output logic [NUM_THR-1:0]              hold_o
);
  logic [NUM_THR-1:0] miss_over, grp_over, over, idle, start;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    thr_load_mon #(.CW(MISS_W)) miss_mon_i (
      .count_i (miss_cnt_i[t]),
      .limit_i (miss_limit_i),
      .over_o  (miss_over[t])
    );
    thr_load_mon #(.CW(GRP_W)) grp_mon_i (
      .count_i (grp_cnt_i[t]),
      .limit_i (grp_limit_i),
      .over_o  (grp_over[t])
    );
    assign over[t] = miss_over[t] | grp_over[t];

    thr_escalator #(.DWELL_W(DWELL_W)) esc_i (
      .clk       (clk),
      .rst       (rst),
      .start_i   (start[t]),
      .over_i    (over[t]),
      .clr_i     (clr_i[t]),
      .inh_lim_i (inhibit_after_i),
      .fl_lim_i  (flush_after_i),
      .prio_o    (prio_down_o[t]),
      .blk_o     (decode_block_o[t]),
      .flush_o   (flush_o[t]),
      .hold_o    (hold_o[t]),
      .idle_o    (idle[t])
    );
  end

  thr_admit #(.NT(NUM_THR)) admit_i (
    .over_i  (over),
    .idle_i  (idle),
    .start_o (start)
  );
endmodule

// File: rtl/thr_balancer_chk.sv
module thr_balancer_chk #(
  parameter int MISS_W  = 5,
  parameter int GRP_W   = 6,
  parameter int DWELL_W = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic [1:0][MISS_W-1:0] miss_cnt_i,
  input logic [1:0][GRP_W-1:0]  grp_cnt_i,
  input logic [MISS_W-1:0]      miss_limit_i,
  input logic [GRP_W-1:0]       grp_limit_i,
  input logic [DWELL_W-1:0]     inhibit_after_i,
  input logic [DWELL_W-1:0]     flush_after_i,
  input logic [1:0]             clr_i,
  input logic [1:0]             prio_down_o,
  input logic [1:0]             decode_block_o,
  input logic [1:0]             flush_o,
  input logic [1:0]             hold_o
);
  logic [1:0] ovr;
  assign ovr[0] = (miss_cnt_i[0] >= miss_limit_i) || (grp_cnt_i[0] >= grp_limit_i);
  assign ovr[1] = (miss_cnt_i[1] >= miss_limit_i) || (grp_cnt_i[1] >= grp_limit_i);

  assert_single_thread_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(prio_down_o));

  assert_mutual_none_R8: assert property (@(posedge clk) disable iff (rst)
    (prio_down_o == 2'b00 && ovr == 2'b11) |=> (prio_down_o == 2'b00));

  for (genvar t = 0; t < 2; t++) begin : g_chk
    localparam int OTH = 1 - t;

    assert_start_R2: assert property (@(posedge clk) disable iff (rst)
      (prio_down_o == 2'b00 && ovr[t] && !ovr[OTH]) |=> prio_down_o[t]);

    assert_layer_R4: assert property (@(posedge clk) disable iff (rst)
      decode_block_o[t] |-> prio_down_o[t]);

    assert_flush_pulse_R5: assert property (@(posedge clk) disable iff (rst)
      flush_o[t] |=> !flush_o[t]);

    assert_flush_hold_R5: assert property (@(posedge clk) disable iff (rst)
      flush_o[t] |-> (hold_o[t] && decode_block_o[t]));

    assert_release_R6: assert property (@(posedge clk) disable iff (rst)
      (prio_down_o[t] && !ovr[t] && clr_i[t]) |=>
        !(prio_down_o[t] || decode_block_o[t] || flush_o[t] || hold_o[t]));

    assert_pause_R9: assert property (@(posedge clk) disable iff (rst)
      (prio_down_o[t] && !ovr[t] && !clr_i[t]) |=>
        ($stable(prio_down_o[t]) && $stable(decode_block_o[t]) &&
         $stable(hold_o[t]) && !flush_o[t]));
  end
endmodule

bind throttle_balancer thr_balancer_chk #(
  .MISS_W(MISS_W), .GRP_W(GRP_W), .DWELL_W(DWELL_W)
) chk_i (.*);

// File: tb/throttle_balancer_tb_top.sv
`timescale 1ns/1ps
module throttle_balancer_tb_top;
  localparam int MW = 5;
  localparam int GW = 6;
  localparam int DW = 8;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [1:0][MW-1:0] miss_cnt = '0;
  logic [1:0][GW-1:0] grp_cnt  = '0;
  logic [MW-1:0]      miss_lim = 5'd4;
  logic [GW-1:0]      grp_lim  = 6'd10;
  logic [DW-1:0]      inh_lim  = 8'd3;
  logic [DW-1:0]      fl_lim   = 8'd6;
  logic [1:0]         clr      = '0;
  logic [1:0]         prio, blk, fl, hold;

  throttle_balancer #(.MISS_W(MW), .GRP_W(GW), .DWELL_W(DW)) dut_i (
    .clk(clk), .rst(rst),
    .miss_cnt_i(miss_cnt), .grp_cnt_i(grp_cnt),
    .miss_limit_i(miss_lim), .grp_limit_i(grp_lim),
    .inhibit_after_i(inh_lim), .flush_after_i(fl_lim),
    .clr_i(clr),
    .prio_down_o(prio), .decode_block_o(blk), .flush_o(fl), .hold_o(hold)
  );

  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [7:0] q_exp[$];
  string      q_tag[$];

  // Reference model, written from the requirements.
  int m_lvl[2];
  int m_cnt[2];
  bit m_fl[2];

  task automatic model_step();
    bit ov[2];
    int nl[2];
    int nc[2];
    bit nf[2];
    for (int t = 0; t < 2; t++)
      ov[t] = (miss_cnt[t] >= miss_lim) || (grp_cnt[t] >= grp_lim);
    for (int t = 0; t < 2; t++) begin
      int o = 1 - t;
      nl[t] = m_lvl[t]; nc[t] = m_cnt[t]; nf[t] = 0;
      if (rst) begin
        nl[t] = 0; nc[t] = 0;
      end else if (m_lvl[t] == 0) begin
        if (ov[t] && !ov[o] && m_lvl[o] == 0) begin nl[t] = 1; nc[t] = 0; end
      end else if (!ov[t] && clr[t]) begin
        nl[t] = 0; nc[t] = 0;
      end else if (ov[t]) begin
        nc[t] = (m_cnt[t] == 255) ? 255 : m_cnt[t] + 1;
        if (m_lvl[t] < 3 && nc[t] >= fl_lim) begin nl[t] = 3; nf[t] = 1; end
        else if (m_lvl[t] == 1 && nc[t] >= inh_lim) nl[t] = 2;
      end
    end
    for (int t = 0; t < 2; t++) begin
      m_lvl[t] = nl[t]; m_cnt[t] = nc[t]; m_fl[t] = nf[t];
    end
  endtask

  function automatic logic [7:0] model_out();
    logic [7:0] v;
    for (int t = 0; t < 2; t++) begin
      v[t]   = (m_lvl[t] >= 1);
      v[2+t] = (m_lvl[t] >= 2);
      v[4+t] = m_fl[t];
      v[6+t] = (m_lvl[t] == 3);
    end
    return v;
  endfunction

  // Driver: apply inputs away from the edge and queue the expectation.
  task automatic drive(input bit r, input int m0, input int m1,
                       input int g0, input int g1, input logic [1:0] c,
                       input string tag);
    @(negedge clk);
    rst = r;
    miss_cnt[0] = MW'(m0); miss_cnt[1] = MW'(m1);
    grp_cnt[0]  = GW'(g0); grp_cnt[1]  = GW'(g1);
    clr = c;
    model_step();
    q_exp.push_back(model_out());
    q_tag.push_back(tag);
  endtask

  // Monitor: compare after each edge.
  always @(posedge clk) begin
    #1;
    if (q_exp.size() > 0) begin
      logic [7:0] e, a;
      string tg;
      e  = q_exp.pop_front();
      tg = q_tag.pop_front();
      a  = {hold, fl, blk, prio};
      n_checks++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: {hold,flush,block,prio} actual=%b expected=%b", tg, a, e);
      end
    end
  end

  initial begin
    for (int t = 0; t < 2; t++) begin m_lvl[t] = 0; m_cnt[t] = 0; m_fl[t] = 0; end
    // R1: reset state
    drive(1, 0, 0, 0, 0, 2'b00, "R1");
    drive(1, 9, 0, 0, 0, 2'b00, "R1");
    drive(0, 0, 0, 0, 0, 2'b00, "R1");
    // R2 boundary: one below the miss limit does nothing
    drive(0, 3, 0, 0, 0, 2'b00, "R2");
    drive(0, 3, 0, 9, 0, 2'b00, "R2");
    // R2, R4, R5: thread 0 misses at limit, full escalation
    for (int i = 0; i < 9; i++) drive(0, 4, 0, 0, 0, 2'b00, (i < 3) ? "R2" : (i < 6) ? "R4" : "R5");
    // R9: below limits without clear holds the level
    for (int i = 0; i < 3; i++) drive(0, 0, 0, 0, 0, 2'b00, "R9");
    // R6: release
    drive(0, 0, 0, 0, 0, 2'b01, "R6");
    drive(0, 0, 0, 0, 0, 2'b00, "R6");
    // R3, R7, R8: thread 1 via completion entries; thread 0 later over but not admitted
    drive(0, 0, 0, 0, 10, 2'b00, "R3");
    drive(0, 0, 0, 0, 12, 2'b00, "R3");
    for (int i = 0; i < 4; i++) drive(0, 6, 0, 0, 12, 2'b00, "R7");
    drive(0, 6, 0, 0, 3, 2'b00, "R8");
    drive(0, 6, 0, 0, 3, 2'b10, "R6");
    drive(0, 6, 0, 0, 3, 2'b00, "R7");
    drive(0, 0, 0, 0, 0, 2'b01, "R6");
    drive(0, 0, 0, 0, 0, 2'b00, "R6");
    // R8: both over together
    for (int i = 0; i < 4; i++) drive(0, 5, 0, 0, 11, 2'b00, "R8");
    drive(0, 0, 0, 0, 0, 2'b00, "R8");
    // R9: pause mid-escalation then resume
    for (int i = 0; i < 4; i++) drive(0, 4, 0, 0, 0, 2'b00, "R4");
    for (int i = 0; i < 4; i++) drive(0, 0, 0, 0, 0, 2'b00, "R9");
    for (int i = 0; i < 4; i++) drive(0, 7, 0, 0, 0, 2'b00, "R9");
    // over with clear high: no release
    drive(0, 7, 0, 0, 0, 2'b01, "R6");
    drive(0, 0, 0, 0, 0, 2'b01, "R6");
    drive(0, 0, 0, 0, 0, 2'b00, "R1");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule